// File: doc/BRIEF.md
# Programmable Seconds Watchdog Timer

This block is a watchdog timer that lives inside a logical device and is programmed through three byte-wide configuration registers: a countdown register, a control register and a status register. Software arms it by writing a nonzero count to the countdown register. Every time unit the count drops by one, and reading the register returns the time left. Software keeps the system alive by rewriting a nonzero count before the count runs out. Writing zero stops the timer.

The time unit is one second, taken from an external one-second tick input. If the control register selects minute units, an internal prescaler divides the tick by 60. When a time-unit tick takes the count from one to zero, the block sets an expiry flag in the status register and drives an active-low reset pulse of fixed length. If the control register allows it, the same pulse also appears on a keyboard-reset output. Some control and status bits are only stored so software can read them back: the keyboard-stop enable and the keyboard and mouse event enables.

Top module: `sec_watchdog`

## Requirements
- R1: After reset, all three registers read 0x00, the watchdog is disabled, and both `wdt_rst_n` and `kbd_rst_n` are high.
- R2: While the countdown register holds 0, ticks neither change it nor cause an expiry. Writing 0 to index 0xF6 stops a running count.
- R3: A write to index 0xF6 loads the written value, which is visible from the next cycle. A write in the same cycle as a counting tick wins over the tick. A nonzero write while the timer runs is the keep-alive.
- R4: In second mode (control bit 3 = 0), each `sec_tick` cycle with a nonzero count lowers the count by exactly one. Reading index 0xF6 returns the remaining count.
- R5: A counting tick that takes the count from 1 to 0 sets status bit 4 (index 0xF7) in the next cycle. The count then stays at 0.
- R6: `wdt_rst_n` goes low in the cycle after the expiring tick and stays low for exactly 16 clock cycles.
- R7: `kbd_rst_n` carries the same low pulse only while control bit 1 (index 0xF5) is 1. Otherwise it stays high.
- R8: Writing status bit 4 as 0 clears the expiry flag. Writing it as 1 does not set it. An expiry in the same cycle as a status write leaves the flag set.
- R9: With control bit 3 = 1 (minute mode), the count drops once every 60 `sec_tick` pulses, counted from the most recent load.
- R10: Writes to any index other than 0xF5, 0xF6 or 0xF7 change nothing. Reads of such an index return 0x00.
- R11: All control bits and status bits 7:5 and 3:0 read back as written. Control bit 2 and status bits 7 and 6 (the keyboard-stop and keyboard/mouse event enables) do not affect counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| wdt_rst_n | output | 1 | Active-low expiry reset pulse |
| kbd_rst_n | output | 1 | Active-low keyboard-reset pulse, gated by control bit 1 |

## Verification
Every register write and every tick takes effect at the next rising edge. Because `cfg_rdata` is a combinational decode of the registers, a value can be read back one cycle after the stimulus. The expiry flag and the falling edge of `wdt_rst_n` both appear in the cycle right after the tick that reaches zero, and the pulse then spans 16 cycles. The bench drives each stimulus at a falling edge and lets one rising edge pass. It then samples at the next falling edge, after a short settle for the read address, and compares against a bench model advanced at that same edge. The pulse length is measured by counting low samples over a window longer than the pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int REG_W          = 8;
    localparam int CTRL_KBRST_BIT = 1;
    localparam int CTRL_KSTOP_BIT = 2;
    localparam int CTRL_MIN_BIT   = 3;
    localparam int STAT_EXP_BIT   = 4;

    typedef logic [REG_W-1:0] reg_t;

    typedef struct packed {
        reg_t ctrl;
        reg_t stat;
    } cfg_state_t;

    typedef struct packed {
        reg_t count;
    } tmr_state_t;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int DIV = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic minute_mode,
    input  logic clear,
    output logic unit_tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            logic [CW-1:0] cnt_d, cnt_q;
            logic          wrap;

            always_comb begin
                wrap  = (cnt_q == CW'(DIV - 1));
                cnt_d = cnt_q;
                if (clear || !minute_mode)
                    cnt_d = '0;
                else if (sec_tick)
                    cnt_d = wrap ? '0 : cnt_q + 1'b1;
                unit_tick = sec_tick && (!minute_mode || wrap);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= CW'(DIV - 1)); // R9
            AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
                (minute_mode && !clear && sec_tick && wrap) |=> (cnt_q == '0)); // R9
        end else begin : g_pass
            logic unused_ok;
            assign unused_ok = minute_mode ^ clear ^ clk ^ rst_n;
            assign unit_tick = sec_tick;
        end
    endgenerate
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire)
            cnt_d = CW'(LEN);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        active = (cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> active); // R6
    AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(1) && !fire) |=> !active); // R6
endmodule

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic wr_stat,
    input  reg_t wdata,
    input  logic expire,
    output reg_t ctrl,
    output reg_t stat
);
    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_ctrl)
            s_d.ctrl = wdata;
        if (wr_stat) begin
            s_d.stat = wdata;
            s_d.stat[STAT_EXP_BIT] = wdata[STAT_EXP_BIT] & s_q.stat[STAT_EXP_BIT];
        end
        if (expire)
            s_d.stat[STAT_EXP_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl = s_q.ctrl;
    assign stat = s_q.stat;

    AST_EXP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> stat[STAT_EXP_BIT]); // R5
    AST_EXP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[STAT_EXP_BIT] && !wr_stat) |=> stat[STAT_EXP_BIT]); // R8
    AST_EXP_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat[STAT_EXP_BIT] && !expire) |=> !stat[STAT_EXP_BIT]); // R8
endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
    import wdt_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          MIN_DIV   = 60,
    parameter int          PULSE_LEN = 16,
    parameter logic [7:0]  IDX_CTRL  = 8'hF5,
    parameter logic [7:0]  IDX_COUNT = 8'hF6,
    parameter logic [7:0]  IDX_STAT  = 8'hF7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              wdt_rst_n,
    output logic              kbd_rst_n
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(IDX_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(IDX_COUNT);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(IDX_STAT);

    tmr_state_t t_d, t_q;
    reg_t       ctrl, stat;
    logic       hit_count, hit_ctrl, hit_stat;
    logic       running, pre_tick, unit, expire, pulse_on;

    always_comb begin
        hit_count = cfg_wr && (cfg_addr == A_COUNT);
        hit_ctrl  = cfg_wr && (cfg_addr == A_CTRL);
        hit_stat  = cfg_wr && (cfg_addr == A_STAT);
        running   = (t_q.count != '0);
        unit      = pre_tick && running;
        expire    = unit && !hit_count && (t_q.count == REG_W'(1));

        t_d = t_q;
        if (hit_count)
            t_d.count = cfg_wdata;
        else if (unit)
            t_d.count = t_q.count - 1'b1;

        case (cfg_addr)
            A_CTRL:  cfg_rdata = ctrl;
            A_COUNT: cfg_rdata = t_q.count;
            A_STAT:  cfg_rdata = stat;
            default: cfg_rdata = '0;
        endcase

        wdt_rst_n = !pulse_on;
        kbd_rst_n = !(pulse_on && ctrl[CTRL_KBRST_BIT]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    wdt_prescale #(.DIV(MIN_DIV)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_tick    (sec_tick),
        .minute_mode (ctrl[CTRL_MIN_BIT]),
        .clear       (hit_count || !running),
        .unit_tick   (pre_tick)
    );

    wdt_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (hit_ctrl),
        .wr_stat (hit_stat),
        .wdata   (cfg_wdata),
        .expire  (expire),
        .ctrl    (ctrl),
        .stat    (stat)
    );

    wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (expire),
        .active (pulse_on)
    );

    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count |=> (t_q.count == $past(cfg_wdata))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !hit_count) |=> (t_q.count == '0)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !hit_count) |=> (t_q.count <= $past(t_q.count))); // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !hit_count && sec_tick && !ctrl[CTRL_MIN_BIT])
        |=> (t_q.count == $past(t_q.count) - 1'b1)); // R4
    AST_RST_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst_n) |-> stat[STAT_EXP_BIT]); // R5
    AST_KBD_WITHIN_WDT: assert property (@(posedge clk) disable iff (!rst_n)
        !kbd_rst_n |-> !wdt_rst_n); // R7
endmodule

// File: tb/sec_watchdog_tb.sv
module sec_watchdog_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    wire  [7:0] cfg_rdata;
    wire        wdt_rst_n;
    wire        kbd_rst_n;

    always #5 clk = ~clk;

    sec_watchdog u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .wdt_rst_n (wdt_rst_n),
        .kbd_rst_n (kbd_rst_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    // bench model of the requirements
    logic [7:0] m_count = 8'h00, m_ctrl = 8'h00, m_stat = 8'h00;
    int m_pre = 0;
    int m_pulse = 0;

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'hF5:   return m_ctrl;
            8'hF6:   return m_count;
            8'hF7:   return m_stat;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic wr, input logic [7:0] a, input logic [7:0] d, input logic tick);
        logic       wcnt, unit, exp_now;
        logic [7:0] nc, ns, nctl;
        int         np, npl;
        wcnt    = wr && a == 8'hF6;
        unit    = tick && m_count != 0 && (m_ctrl[3] ? (m_pre == 59) : 1'b1);
        exp_now = unit && !wcnt && m_count == 8'd1;
        if (wcnt || m_count == 0 || !m_ctrl[3]) np = 0;
        else if (tick) np = (m_pre == 59) ? 0 : m_pre + 1;
        else np = m_pre;
        nc   = wcnt ? d : (unit ? m_count - 8'd1 : m_count);
        nctl = (wr && a == 8'hF5) ? d : m_ctrl;
        ns   = m_stat;
        if (wr && a == 8'hF7) ns = {d[7:5], d[4] & m_stat[4], d[3:0]};
        if (exp_now) ns[4] = 1'b1;
        npl = exp_now ? 16 : (m_pulse > 0 ? m_pulse - 1 : 0);
        m_count = nc; m_ctrl = nctl; m_stat = ns; m_pre = np; m_pulse = npl;
    endtask

    task automatic cyc(input logic wr, input logic [7:0] a, input logic [7:0] d, input logic tick);
        cfg_wr = wr; cfg_addr = a; cfg_wdata = d; sec_tick = tick;
        @(posedge clk);
        model_step(wr, a, d, tick);
        @(negedge clk);
        cfg_wr = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic out_chk(input string tag);
        check({tag, " wdt_rst_n"}, wdt_rst_n, (m_pulse == 0));
        check({tag, " kbd_rst_n"}, kbd_rst_n, !(m_pulse != 0 && m_ctrl[1]));
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int low_cnt;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk(8'hF5, 8'h00, "R1 ctrl reset");
        rd_chk(8'hF6, 8'h00, "R1 count reset");
        rd_chk(8'hF7, 8'h00, "R1 stat reset");
        out_chk("R1");

        // R2 idle ticks do nothing
        repeat (3) cyc(1'b0, 8'h00, 8'h00, 1'b1);
        rd_chk(8'hF6, 8'h00, "R2 idle count");
        out_chk("R2 idle");

        // R3 load, R4 decrement
        cyc(1'b1, 8'hF6, 8'd5, 1'b0);
        rd_chk(8'hF6, 8'd5, "R3 load");
        cyc(1'b0, 8'h00, 8'h00, 1'b1);
        cyc(1'b0, 8'h00, 8'h00, 1'b1);
        rd_chk(8'hF6, 8'd3, "R4 two ticks");
        cyc(1'b1, 8'hF6, 8'd10, 1'b0);
        rd_chk(8'hF6, 8'd10, "R3 keep-alive");
        cyc(1'b1, 8'hF6, 8'd7, 1'b1);
        rd_chk(8'hF6, 8'd7, "R3 write beats tick");

        // R2 stop
        cyc(1'b1, 8'hF6, 8'd0, 1'b0);
        repeat (4) cyc(1'b0, 8'h00, 8'h00, 1'b1);
        rd_chk(8'hF6, 8'd0, "R2 stopped");
        rd_chk(8'hF7, 8'h00, "R2 no expiry");
        out_chk("R2 stopped");

        // R5/R6 expiry, kbd disabled (R7)
        cyc(1'b1, 8'hF6, 8'd2, 1'b0);
        cyc(1'b0, 8'h00, 8'h00, 1'b1);
        cyc(1'b0, 8'h00, 8'h00, 1'b1);
        rd_chk(8'hF6, 8'd0, "R5 count zero");
        rd_chk(8'hF7, 8'h10, "R5 flag set");
        check("R7 kbd idle when disabled", kbd_rst_n, 1'b1);
        low_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            if (!wdt_rst_n) low_cnt++;
            out_chk("R6 pulse");
            cyc(1'b0, 8'h00, 8'h00, 1'b1);
        end
        check("R6 pulse length", low_cnt, 16);
        rd_chk(8'hF6, 8'd0, "R5 stays zero");

        // R8 flag clear rules
        cyc(1'b1, 8'hF7, 8'h10, 1'b0);
        rd_chk(8'hF7, 8'h10, "R8 write one keeps");
        cyc(1'b1, 8'hF7, 8'h00, 1'b0);
        rd_chk(8'hF7, 8'h00, "R8 cleared");
        cyc(1'b1, 8'hF7, 8'h10, 1'b0);
        rd_chk(8'hF7, 8'h00, "R8 write one no set");

        // R7 keyboard reset enabled, R8 expiry beats clear
        cyc(1'b1, 8'hF5, 8'h02, 1'b0);
        cyc(1'b1, 8'hF6, 8'd1, 1'b0);
        cyc(1'b1, 8'hF7, 8'h00, 1'b1);
        rd_chk(8'hF7, 8'h10, "R8 expiry beats clear");
        low_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            if (!kbd_rst_n) low_cnt++;
            out_chk("R7 kbd pulse");
            cyc(1'b0, 8'h00, 8'h00, 1'b0);
        end
        check("R7 kbd pulse length", low_cnt, 16);

        // R11 storage bits, no effect on counting
        cyc(1'b1, 8'hF5, 8'hF4, 1'b0);
        cyc(1'b1, 8'hF7, 8'hEF, 1'b0);
        rd_chk(8'hF5, 8'hF4, "R11 ctrl readback");
        rd_chk(8'hF7, 8'hE0 | 8'h0F, "R11 stat readback");
        cyc(1'b1, 8'hF5, 8'h04, 1'b0);
        cyc(1'b1, 8'hF6, 8'd4, 1'b0);
        cyc(1'b0, 8'h00, 8'h00, 1'b1);
        rd_chk(8'hF6, 8'd3, "R11 kbd-stop bit ignored");

        // R9 minute mode
        cyc(1'b1, 8'hF5, 8'h08, 1'b0);
        cyc(1'b1, 8'hF6, 8'd2, 1'b0);
        repeat (59) cyc(1'b0, 8'h00, 8'h00, 1'b1);
        rd_chk(8'hF6, 8'd2, "R9 59 ticks");
        cyc(1'b0, 8'h00, 8'h00, 1'b1);
        rd_chk(8'hF6, 8'd1, "R9 60th tick");
        repeat (30) cyc(1'b0, 8'h00, 8'h00, 1'b1);
        cyc(1'b1, 8'hF6, 8'd1, 1'b0);
        repeat (59) cyc(1'b0, 8'h00, 8'h00, 1'b1);
        rd_chk(8'hF6, 8'd1, "R9 reload restarts prescale");
        cyc(1'b0, 8'h00, 8'h00, 1'b1);
        rd_chk(8'hF6, 8'd0, "R9 minute expiry");
        out_chk("R9 minute expiry");

        // R10 unknown index
        cyc(1'b1, 8'hF5, 8'h00, 1'b0);
        cyc(1'b1, 8'hF6, 8'd9, 1'b0);
        cyc(1'b1, 8'hF4, 8'h55, 1'b0);
        cyc(1'b1, 8'h30, 8'hAA, 1'b0);
        rd_chk(8'hF6, 8'd9, "R10 count untouched");
        rd_chk(8'hF5, 8'h00, "R10 ctrl untouched");
        rd_chk(8'hF4, 8'h00, "R10 read unknown");

        // R4 random mix against the model
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            logic [7:0] a;
            r = $urandom_range(99);
            if (r < 60)      cyc(1'b0, 8'h00, 8'h00, 1'b1);
            else if (r < 78) cyc(1'b1, 8'hF6, 8'($urandom_range(6)), $urandom_range(1) == 1);
            else if (r < 85) cyc(1'b0, 8'h00, 8'h00, 1'b0);
            else if (r < 90) cyc(1'b1, 8'hF5, 8'($urandom_range(255)) & 8'hF7, 1'b0);
            else if (r < 95) cyc(1'b1, 8'hF7, 8'($urandom_range(255)), $urandom_range(1) == 1);
            else             cyc(1'b1, 8'($urandom_range(255)), 8'($urandom_range(255)), 1'b1);
            a = (i % 3 == 0) ? 8'hF6 : ((i % 3 == 1) ? 8'hF7 : 8'hF5);
            rd_chk(a, exp_read(a), "R4 random read");
            out_chk("R4 random");
        end

        summary();
        $finish;
    end
endmodule